// File: doc/BRIEF.md
# Secondary Core Wake-Up Sequencer

This block brings secondary processor cores out of reset one at a time. It walks a table of slots. Each slot holds a core ID and an enable bit, and only enabled slots are ever addressed. A message is never broadcast. For each enabled core the block issues a reset-style INIT message, lets a fixed settling delay elapse, and then issues a START message. It then watches a started-status input for a bounded window.

If the core reports in time, the block returns a one-cycle acknowledge tagged with that core's ID. The core is expected to hold off its own initialisation until it sees this acknowledge. If the first window closes silently, the block sends one more START message and opens a second, longer window. If that window also closes silently, the core is marked as failed and the walk moves on.

All delays are given in milliseconds. They are converted to clock cycles through a cycles-per-millisecond parameter, so a testbench can shrink real time. A per-slot pass vector and fail vector record the outcome. A done flag rises once the last slot has been handled.

Top module: `core_wake_seq`

## Requirements
- R1: While reset is asserted, msg_valid_o, ack_o and done_o are 0 and both pass_vec_o and fail_vec_o are all zeros. A reset applied after a finished walk clears both vectors.
- R2: A slot whose tbl_en_i reads 0 produces no message and no acknowledge, and leaves its bits in pass_vec_o and fail_vec_o at 0. The walk proceeds to the next slot.
- R3: For every enabled slot, the first message sent carries msg_kind_o = 0 (INIT) and msg_dest_o equal to that slot's tbl_id_i. START messages carry msg_kind_o = 1. While msg_valid_o is high and msg_ready_i is low, msg_valid_o, msg_kind_o and msg_dest_o hold their values.
- R4: With msg_ready_i held high, exactly WAIT_MS*CYC_PER_MS cycles with msg_valid_o low separate the INIT handshake cycle from the first START message.
- R5: started_i is ignored outside the poll windows. A started pulse during the INIT wait produces no acknowledge.
- R6: started_i seen in any cycle of a poll window yields, on the following cycle, a single-cycle ack_o with ack_id_o equal to the core ID. The slot's pass_vec_o bit is set the cycle after that.
- R7: If the first window, of POLL1_MS*CYC_PER_MS cycles counted from the cycle after the START handshake, closes without started_i, a second START to the same core is valid on the very next cycle. It is followed by a window of POLL2_MS*CYC_PER_MS cycles.
- R8: started_i in the last cycle of either window counts as success.
- R9: If the second window closes without started_i, no acknowledge is given and the slot's fail_vec_o bit is set. A slot never has both bits set.
- R10: done_o rises on the cycle after the last slot is handled and stays high until reset. While it is high, no message or acknowledge is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_addr_o | output | IDX_W | Slot index being read from the target table |
| tbl_en_i | input | 1 | Slot enable at tbl_addr_o (combinational read) |
| tbl_id_i | input | ID_W | Core ID at tbl_addr_o (combinational read) |
| msg_valid_o | output | 1 | Message request |
| msg_ready_i | input | 1 | Message accepted when high with msg_valid_o |
| msg_kind_o | output | 1 | 0 = INIT, 1 = START |
| msg_dest_o | output | ID_W | Destination core ID |
| started_i | input | 1 | Started status from the core being woken |
| ack_o | output | 1 | One-cycle acknowledge to the started core |
| ack_id_o | output | ID_W | Core ID being acknowledged |
| pass_vec_o | output | NUM_SLOTS | Per-slot success flags |
| fail_vec_o | output | NUM_SLOTS | Per-slot failure flags |
| done_o | output | 1 | Walk complete |

## Verification
A stuck or misloaded delay counter shows up at the ports as a wrong count of idle cycles between the INIT handshake and the START request. It can also show up as a retry or a failure that begins one cycle early or late, so every window edge is probed on its exact cycle. The last cycle of each window is exercised for acceptance. A lost retry flag would put a core into a second retry or skip its second window, and the retry-then-fail path exposes this within one window length. An index or vector fault appears as a message to the wrong ID, or a misplaced result bit, on the first slot after a disabled one.

// File: rtl/core_wake_pkg.sv
`timescale 1ns/1ps
package core_wake_pkg;

   typedef enum logic [2:0] {
      WK_FETCH  = 3'd0,
      WK_INIT   = 3'd1,
      WK_SETTLE = 3'd2,
      WK_KICK   = 3'd3,
      WK_WATCH  = 3'd4,
      WK_GRANT  = 3'd5,
      WK_GIVEUP = 3'd6,
      WK_FIN    = 3'd7
   } wake_state_e;

   typedef enum logic {
      MK_INIT  = 1'b0,
      MK_START = 1'b1
   } msg_kind_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/core_wake_timer.sv
`timescale 1ns/1ps
module core_wake_timer #(
   parameter int unsigned CYC_PER_MS = 200000,
   parameter int unsigned MAX_MS     = 10,
   parameter int unsigned MS_W       = 4,
   parameter bit          PRESCALED  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [MS_W-1:0] ms_i,
   output logic            zero_o
);

   if (CYC_PER_MS < 1) begin : g_bad_cpm
      $error("core_wake_timer: CYC_PER_MS must be at least 1");
   end
   if (MAX_MS >= (1 << MS_W)) begin : g_bad_msw
      $error("core_wake_timer: MS_W too narrow for MAX_MS");
   end

   if (PRESCALED) begin : g_prescaled
      localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
      localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(CYC_PER_MS - 1);

      logic [PRE_W-1:0] pre_q;
      logic [MS_W-1:0]  ms_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
         end else if (load_i) begin
            pre_q <= PRE_LOAD;
            ms_q  <= ms_i - MS_W'(1);
         end else if (pre_q != '0) begin
            pre_q <= pre_q - PRE_W'(1);
         end else if (ms_q != '0) begin
            ms_q  <= ms_q - MS_W'(1);
            pre_q <= PRE_LOAD;
         end
      end

      assign zero_o = (pre_q == '0) && (ms_q == '0);
   end else begin : g_flat
      localparam int unsigned CNT_W = $clog2(MAX_MS * CYC_PER_MS + 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load_i) begin
            cnt_q <= CNT_W'(ms_i) * CNT_W'(CYC_PER_MS) - CNT_W'(1);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      assign zero_o = (cnt_q == '0);
   end

endmodule

// File: rtl/core_wake_walker.sv
`timescale 1ns/1ps
module core_wake_walker #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic                 mark_pass_i,
   input  logic                 mark_fail_i,
   output logic [IDX_W-1:0]     idx_o,
   output logic                 last_o,
   output logic [NUM_SLOTS-1:0] pass_vec_o,
   output logic [NUM_SLOTS-1:0] fail_vec_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (step_i && (idx_q != LAST_IDX)) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = (idx_q == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pass_vec_o[s] <= 1'b0;
            fail_vec_o[s] <= 1'b0;
         end else if (hit) begin
            if (mark_pass_i) pass_vec_o[s] <= 1'b1;
            if (mark_fail_i) fail_vec_o[s] <= 1'b1;
         end
      end
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/core_wake_fsm.sv
`timescale 1ns/1ps
module core_wake_fsm
   import core_wake_pkg::*;
#(
   parameter int unsigned ID_W     = 8,
   parameter int unsigned MS_W     = 4,
   parameter int unsigned WAIT_MS  = 10,
   parameter int unsigned POLL1_MS = 5,
   parameter int unsigned POLL2_MS = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tbl_en_i,
   input  logic [ID_W-1:0] tbl_id_i,
   input  logic            last_i,
   input  logic            msg_ready_i,
   input  logic            started_i,
   input  logic            tmr_zero_i,
   output logic            tmr_load_o,
   output logic [MS_W-1:0] tmr_ms_o,
   output logic            msg_valid_o,
   output logic            msg_kind_o,
   output logic [ID_W-1:0] msg_dest_o,
   output logic            ack_o,
   output logic [ID_W-1:0] ack_id_o,
   output logic            step_o,
   output logic            mark_pass_o,
   output logic            mark_fail_o,
   output logic            done_o
);

   wake_state_e     state_q, state_d;
   logic [ID_W-1:0] dest_q, dest_d;
   logic            retry_q, retry_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_FETCH;
         dest_q  <= '0;
         retry_q <= 1'b0;
      end else begin
         state_q <= state_d;
         dest_q  <= dest_d;
         retry_q <= retry_d;
      end
   end

   always_comb begin
      state_d     = state_q;
      dest_d      = dest_q;
      retry_d     = retry_q;
      tmr_load_o  = 1'b0;
      tmr_ms_o    = MS_W'(WAIT_MS);
      msg_valid_o = 1'b0;
      msg_kind_o  = logic'(MK_INIT);
      ack_o       = 1'b0;
      step_o      = 1'b0;
      mark_pass_o = 1'b0;
      mark_fail_o = 1'b0;
      done_o      = 1'b0;

      unique case (state_q)
         WK_FETCH: begin
            retry_d = 1'b0;
            if (tbl_en_i) begin
               dest_d  = tbl_id_i;
               state_d = WK_INIT;
            end else begin
               step_o  = 1'b1;
               state_d = last_i ? WK_FIN : WK_FETCH;
            end
         end
         WK_INIT: begin
            msg_valid_o = 1'b1;
            msg_kind_o  = logic'(MK_INIT);
            if (msg_ready_i) begin
               tmr_load_o = 1'b1;
               tmr_ms_o   = MS_W'(WAIT_MS);
               state_d    = WK_SETTLE;
            end
         end
         WK_SETTLE: begin
            if (tmr_zero_i) state_d = WK_KICK;
         end
         WK_KICK: begin
            msg_valid_o = 1'b1;
            msg_kind_o  = logic'(MK_START);
            if (msg_ready_i) begin
               tmr_load_o = 1'b1;
               tmr_ms_o   = retry_q ? MS_W'(POLL2_MS) : MS_W'(POLL1_MS);
               state_d    = WK_WATCH;
            end
         end
         WK_WATCH: begin
            if (started_i) begin
               state_d = WK_GRANT;
            end else if (tmr_zero_i) begin
               if (retry_q) begin
                  state_d = WK_GIVEUP;
               end else begin
                  retry_d = 1'b1;
                  state_d = WK_KICK;
               end
            end
         end
         WK_GRANT: begin
            ack_o       = 1'b1;
            mark_pass_o = 1'b1;
            step_o      = 1'b1;
            state_d     = last_i ? WK_FIN : WK_FETCH;
         end
         WK_GIVEUP: begin
            mark_fail_o = 1'b1;
            step_o      = 1'b1;
            state_d     = last_i ? WK_FIN : WK_FETCH;
         end
         WK_FIN: begin
            done_o = 1'b1;
         end
         default: state_d = WK_FIN;
      endcase
   end

   assign msg_dest_o = dest_q;
   assign ack_id_o   = dest_q;

endmodule

// File: rtl/core_wake_seq.sv
`timescale 1ns/1ps
module core_wake_seq
   import core_wake_pkg::*;
#(
   parameter int unsigned NUM_SLOTS  = 4,
   parameter int unsigned ID_W       = 8,
   parameter int unsigned CYC_PER_MS = 200000,
   parameter int unsigned WAIT_MS    = 10,
   parameter int unsigned POLL1_MS   = 5,
   parameter int unsigned POLL2_MS   = 10,
   parameter bit          PRESCALED  = 1'b1,
   localparam int unsigned IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [IDX_W-1:0]     tbl_addr_o,
   input  logic                 tbl_en_i,
   input  logic [ID_W-1:0]      tbl_id_i,
   output logic                 msg_valid_o,
   input  logic                 msg_ready_i,
   output logic                 msg_kind_o,
   output logic [ID_W-1:0]      msg_dest_o,
   input  logic                 started_i,
   output logic                 ack_o,
   output logic [ID_W-1:0]      ack_id_o,
   output logic [NUM_SLOTS-1:0] pass_vec_o,
   output logic [NUM_SLOTS-1:0] fail_vec_o,
   output logic                 done_o
);

   localparam int unsigned MAX_MS = max3(WAIT_MS, POLL1_MS, POLL2_MS);
   localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("core_wake_seq: NUM_SLOTS must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("core_wake_seq: ID_W must be at least 1");
   end
   if (WAIT_MS < 1 || POLL1_MS < 1) begin : g_bad_ms
      $error("core_wake_seq: delays must be at least 1 ms");
   end
   if (POLL2_MS < POLL1_MS) begin : g_bad_retry
      $error("core_wake_seq: retry window must not be shorter than the first");
   end

   logic            tmr_load;
   logic [MS_W-1:0] tmr_ms;
   logic            tmr_zero;
   logic            step, mark_pass, mark_fail, last_slot;

   core_wake_timer #(
      .CYC_PER_MS (CYC_PER_MS),
      .MAX_MS     (MAX_MS),
      .MS_W       (MS_W),
      .PRESCALED  (PRESCALED)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .ms_i   (tmr_ms),
      .zero_o (tmr_zero)
   );

   core_wake_walker #(
      .NUM_SLOTS (NUM_SLOTS),
      .IDX_W     (IDX_W)
   ) i_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step),
      .mark_pass_i (mark_pass),
      .mark_fail_i (mark_fail),
      .idx_o       (tbl_addr_o),
      .last_o      (last_slot),
      .pass_vec_o  (pass_vec_o),
      .fail_vec_o  (fail_vec_o)
   );

   core_wake_fsm #(
      .ID_W     (ID_W),
      .MS_W     (MS_W),
      .WAIT_MS  (WAIT_MS),
      .POLL1_MS (POLL1_MS),
      .POLL2_MS (POLL2_MS)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tbl_en_i    (tbl_en_i),
      .tbl_id_i    (tbl_id_i),
      .last_i      (last_slot),
      .msg_ready_i (msg_ready_i),
      .started_i   (started_i),
      .tmr_zero_i  (tmr_zero),
      .tmr_load_o  (tmr_load),
      .tmr_ms_o    (tmr_ms),
      .msg_valid_o (msg_valid_o),
      .msg_kind_o  (msg_kind_o),
      .msg_dest_o  (msg_dest_o),
      .ack_o       (ack_o),
      .ack_id_o    (ack_id_o),
      .step_o      (step),
      .mark_pass_o (mark_pass),
      .mark_fail_o (mark_fail),
      .done_o      (done_o)
   );

endmodule

// File: rtl/core_wake_seq_chk.sv
`timescale 1ns/1ps
module core_wake_seq_chk #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 msg_valid_o,
   input logic                 msg_ready_i,
   input logic                 msg_kind_o,
   input logic [ID_W-1:0]      msg_dest_o,
   input logic                 ack_o,
   input logic [NUM_SLOTS-1:0] pass_vec_o,
   input logic [NUM_SLOTS-1:0] fail_vec_o,
   input logic                 done_o
);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (!msg_valid_o && !ack_o && !done_o && pass_vec_o == '0 && fail_vec_o == '0));

   p_msg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i) |=>
         (msg_valid_o && $stable(msg_kind_o) && $stable(msg_dest_o)));

   p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   p_ack_sets_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> ($countones(pass_vec_o) == $countones($past(pass_vec_o)) + 1));

   p_ack_not_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !msg_valid_o);

   p_vec_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_vec_o & fail_vec_o) == '0);

   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!msg_valid_o && !ack_o));

endmodule

bind core_wake_seq core_wake_seq_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ID_W      (ID_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .msg_valid_o (msg_valid_o),
   .msg_ready_i (msg_ready_i),
   .msg_kind_o  (msg_kind_o),
   .msg_dest_o  (msg_dest_o),
   .ack_o       (ack_o),
   .pass_vec_o  (pass_vec_o),
   .fail_vec_o  (fail_vec_o),
   .done_o      (done_o)
);

// File: tb/test_core_wake_seq.sv
`timescale 1ns/1ps
module test_core_wake_seq;

   localparam int unsigned NS   = 4;
   localparam int unsigned IW   = 8;
   localparam int unsigned CPM  = 4;
   localparam int unsigned T_W  = 10 * CPM;
   localparam int unsigned T_P1 = 5 * CPM;
   localparam int unsigned T_P2 = 10 * CPM;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    tbl_addr_o;
   logic          tbl_en_i;
   logic [IW-1:0] tbl_id_i;
   logic          msg_valid_o;
   logic          msg_ready_i = 1'b0;
   logic          msg_kind_o;
   logic [IW-1:0] msg_dest_o;
   logic          started_i = 1'b0;
   logic          ack_o;
   logic [IW-1:0] ack_id_o;
   logic [NS-1:0] pass_vec_o, fail_vec_o;
   logic          done_o;

   logic [IW-1:0] ids [NS];
   logic          ens [NS];

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   assign tbl_id_i = ids[tbl_addr_o];
   assign tbl_en_i = ens[tbl_addr_o];

   always #2.5 clk = ~clk;

   core_wake_seq #(
      .NUM_SLOTS (NS), .ID_W (IW), .CYC_PER_MS (CPM)
   ) i_core_wake_seq (
      .clk (clk), .rst_n (rst_n),
      .tbl_addr_o (tbl_addr_o), .tbl_en_i (tbl_en_i), .tbl_id_i (tbl_id_i),
      .msg_valid_o (msg_valid_o), .msg_ready_i (msg_ready_i),
      .msg_kind_o (msg_kind_o), .msg_dest_o (msg_dest_o),
      .started_i (started_i), .ack_o (ack_o), .ack_id_o (ack_id_o),
      .pass_vec_o (pass_vec_o), .fail_vec_o (fail_vec_o), .done_o (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // R1: outputs idle while reset is held, vectors cleared
   task automatic do_reset();
      rst_n = 1'b0; started_i = 1'b0; msg_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(!msg_valid_o && !ack_o && !done_o, "R1", "idle outputs in reset",
          {msg_valid_o, ack_o, done_o}, 0);
      chk(pass_vec_o == '0 && fail_vec_o == '0, "R1", "vectors in reset",
          {pass_vec_o, fail_vec_o}, 0);
      rst_n = 1'b1;
   endtask

   // R3: wait for a message, check kind/dest, stall once, then accept it
   task automatic take_msg(input logic kind, input logic [IW-1:0] dest, input string req);
      int n = 0;
      while (!msg_valid_o && n < 400) begin @(negedge clk); n++; end
      chk(msg_valid_o, req, "message request", msg_valid_o, 1);
      chk(msg_kind_o == kind && msg_dest_o == dest, req, "kind/dest",
          {msg_kind_o, msg_dest_o}, {kind, dest});
      @(negedge clk);
      chk(msg_valid_o && msg_kind_o == kind && msg_dest_o == dest, "R3",
          "held under stall", {msg_valid_o, msg_kind_o, msg_dest_o}, {1'b1, kind, dest});
      msg_ready_i = 1'b1;
      @(negedge clk);
      msg_ready_i = 1'b0;
   endtask

   // R4/R5: count idle cycles after INIT; optionally pulse started during the wait
   task automatic settle_gap(input bit stale);
      int n = 0;
      bit saw_ack = 1'b0;
      while (!msg_valid_o && n < 400) begin
         n++;
         started_i = stale && (n == 2);
         if (ack_o) saw_ack = 1'b1;
         @(negedge clk);
      end
      started_i = 1'b0;
      chk(n == T_W, "R4", "idle cycles after INIT", n, T_W);
      if (stale) chk(!saw_ack, "R5", "ack from stale started", saw_ack, 0);
   endtask

   // R6: assert started in cycle k of the window (at negedge of cycle 1 on entry)
   task automatic poll_hit(input int k, input logic [IW-1:0] dest, input string req);
      bit early = 1'b0;
      for (int c = 1; c < k; c++) begin
         if (ack_o || msg_valid_o) early = 1'b1;
         @(negedge clk);
      end
      chk(!early, req, "activity before started", early, 0);
      started_i = 1'b1;
      @(negedge clk);
      started_i = 1'b0;
      chk(ack_o && ack_id_o == dest, req, "ack and id", {ack_o, ack_id_o}, {1'b1, dest});
      @(negedge clk);
      chk(!ack_o, "R6", "ack is one cycle", ack_o, 0);
   endtask

   // Silent window of p cycles; on exit at cycle p+1
   task automatic poll_miss(input int p, input string req);
      bit act = 1'b0;
      for (int c = 0; c < p; c++) begin
         if (ack_o || msg_valid_o) act = 1'b1;
         @(negedge clk);
      end
      chk(!act, req, "no activity in silent window", act, 0);
   endtask

   task automatic t_mixed_table();
      ids = '{8'h21, 8'h5A, 8'h37, 8'h4C};
      ens = '{1'b1, 1'b0, 1'b1, 1'b1};
      do_reset();
      take_msg(1'b0, 8'h21, "R3");
      settle_gap(1'b0);
      take_msg(1'b1, 8'h21, "R3");
      poll_hit(3, 8'h21, "R6");
      chk(pass_vec_o == 4'b0001, "R6", "pass bit slot 0", pass_vec_o, 4'b0001);
      take_msg(1'b0, 8'h37, "R2");            // slot 1 disabled, skipped
      settle_gap(1'b0);
      take_msg(1'b1, 8'h37, "R3");
      poll_hit(T_P1, 8'h37, "R8");            // last cycle of first window
      take_msg(1'b0, 8'h4C, "R3");
      settle_gap(1'b0);
      take_msg(1'b1, 8'h4C, "R3");
      poll_miss(T_P1, "R7");
      chk(msg_valid_o && msg_kind_o, "R7", "retry START immediate",
          {msg_valid_o, msg_kind_o}, 2'b11);
      take_msg(1'b1, 8'h4C, "R7");
      poll_miss(T_P2, "R9");
      @(negedge clk);
      chk(fail_vec_o == 4'b1000 && pass_vec_o == 4'b0101, "R9", "result vectors",
          {pass_vec_o, fail_vec_o}, {4'b0101, 4'b1000});
      chk(done_o, "R10", "done after last slot", done_o, 1);
      begin
         bit bad = 1'b0;
         for (int c = 0; c < 12; c++) begin
            started_i = 1'b1;
            if (!done_o || msg_valid_o || ack_o) bad = 1'b1;
            @(negedge clk);
         end
         started_i = 1'b0;
         chk(!bad, "R10", "done sticky and quiet", bad, 0);
      end
   endtask

   task automatic t_stale_and_retry();
      ids = '{8'h10, 8'h99, 8'h01, 8'h02};
      ens = '{1'b1, 1'b1, 1'b0, 1'b0};
      do_reset();
      take_msg(1'b0, 8'h10, "R3");
      settle_gap(1'b1);
      take_msg(1'b1, 8'h10, "R3");
      poll_miss(T_P1, "R5");
      chk(msg_valid_o && msg_dest_o == 8'h10, "R7", "retry to same core",
          {msg_valid_o, msg_dest_o}, {1'b1, 8'h10});
      take_msg(1'b1, 8'h10, "R7");
      poll_hit(T_P2, 8'h10, "R8");            // last cycle of second window
      chk(pass_vec_o == 4'b0001, "R8", "pass after late started", pass_vec_o, 4'b0001);
      take_msg(1'b0, 8'h99, "R3");
      settle_gap(1'b0);
      take_msg(1'b1, 8'h99, "R3");
      poll_miss(T_P1, "R7");
      take_msg(1'b1, 8'h99, "R7");
      poll_hit(2, 8'h99, "R7");
      @(negedge clk);
      chk(!done_o, "R10", "done not early", done_o, 0);
      @(negedge clk);
      chk(done_o, "R10", "done timing", done_o, 1);
      chk(pass_vec_o == 4'b0011 && fail_vec_o == 4'b0000, "R2", "vectors",
          {pass_vec_o, fail_vec_o}, {4'b0011, 4'b0000});
   endtask

   task automatic t_all_disabled();
      bit saw_msg = 1'b0;
      ids = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
      ens = '{1'b0, 1'b0, 1'b0, 1'b0};
      do_reset();
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         if (msg_valid_o) saw_msg = 1'b1;
      end
      chk(!done_o, "R10", "done not before last slot", done_o, 0);
      @(negedge clk);
      chk(done_o, "R10", "done after skipping all", done_o, 1);
      chk(!saw_msg && pass_vec_o == '0 && fail_vec_o == '0, "R2", "no traffic for disabled",
          {saw_msg, pass_vec_o, fail_vec_o}, 0);
   endtask

   initial begin
      ids = '{8'h0, 8'h0, 8'h0, 8'h0};
      ens = '{1'b0, 1'b0, 1'b0, 1'b0};
      t_mixed_table();
      t_stale_and_retry();
      t_all_disabled();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual 0 expected 1");
      finish_run();
   end

endmodule